// File: doc/BRIEF.md
# Supply Brownout Event and Reset Controller

This block watches two asynchronous low-voltage comparator flags, one for the main digital supply and one for the analog supply. Each flag is brought into the clock domain and turned into an event on its rising edge. A per-source action field selects what the event does: nothing, a maskable interrupt, a non-maskable interrupt pulse, or a reset request. One shared reset-kind code decides whether a reset request becomes a full power-on reset with an initialization phase, a system reset, or an interrupt instead.

Both sources feed one sticky raw brownout status bit and one reset-cause bit, and software clears them by writing 1. A reset output stays asserted for as long as any supply flag that asked for it stays low-voltage. A full power-on reset then keeps the output asserted for a fixed initialization interval, and it puts the configuration back to its defaults. A small word-wide register port gives access to configuration and status. Writes are ignored while either reset output is asserted.

Top module: `bod_reset_ctrl`

## Requirements
- R1: After the external reset the control register reads 6'h33 (main action 3 in bits [1:0], analog action 0 in bits [3:2], reset-kind code 3 in bits [5:4]), the mask register (address 1, bit 0) reads 0, the status register (address 2) reads 0, and irq_o, nmi_o, por_o and sysrst_o are all low.
- R2: A source whose action code is 0 leaves the status bits, irq_o, nmi_o, por_o and sysrst_o unchanged.
- R3: Action code 1 sets the raw status bit (status bit 0). Status bit 1 and irq_o equal the raw bit ANDed with the mask bit.
- R4: Action code 2 sets the raw status bit and drives nmi_o high for exactly one clock cycle.
- R5: Action code 3 with reset-kind code 3 asserts por_o and puts the control and mask registers back to their defaults. por_o stays high while the flag stays high, and for INIT_CYCLES (default 16) more cycles after the flag is seen low.
- R6: Action code 3 with reset-kind code 2 asserts sysrst_o and leaves the configuration as it is. sysrst_o is released three rising edges after the last requesting flag falls.
- R7: Action code 3 with reset-kind code 0 or 1 gives no reset. It sets the raw status bit, as an interrupt does, and leaves the cause bit (status bit 2) clear.
- R8: The cause bit is set by any event that requests a reset. It survives a system reset and is cleared by writing 1 to status bit 2 or by the external reset.
- R9: Events from either source set the same raw status bit, and writing 1 to status bit 0 clears it.
- R10: When a new event and a write-1 clear of the same status bit reach the same clock edge, the bit ends up set.
- R11: Register writes are ignored while por_o or sysrst_o is high.
- R12: A flag rising before clock edge k takes effect at the outputs right after edge k+2: two synchronizer stages, then one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External power-on reset, active low, asynchronous |
| main_low_i | input | 1 | Main-supply brownout comparator flag, asynchronous |
| ana_low_i | input | 1 | Analog-supply brownout comparator flag, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 mask, 2 status |
| reg_wdata_i | input | 6 | Register write data |
| reg_rdata_o | output | 6 | Register read data, combinational from the address |
| irq_o | output | 1 | Maskable brownout interrupt (level) |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| por_o | output | 1 | Full power-on reset request |
| sysrst_o | output | 1 | System reset request |

## Verification
The status bit can be set by a synchronized comparator event and cleared by a software write-1 at the same clock edge. The bench first leaves the raw bit set from an analog event. It then raises the main flag and times a clear write so that it is sampled on the exact edge where the event registers, two edges after the flag is seen. The bit must read 1 afterwards, and a later clear on its own must bring it to 0. The bench also writes the control register while a full power-on reset is asserted, and the defaults must survive that write.

// File: rtl/bod_pkg.sv
package bod_pkg;

   localparam int unsigned NUM_SRC  = 2;
   localparam int unsigned SRC_MAIN = 0;
   localparam int unsigned SRC_ANA  = 1;
   localparam int unsigned REG_W    = 2 * NUM_SRC + 2;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_MASK = 2'd1;
   localparam logic [1:0] ADDR_STAT = 2'd2;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_IRQ   = 2'd1,
      ACT_NMI   = 2'd2,
      ACT_RESET = 2'd3
   } bod_act_e;

   typedef enum logic [1:0] {
      SEQ_RUN,
      SEQ_HOLD_POR,
      SEQ_HOLD_SYS,
      SEQ_INIT
   } bod_seq_e;

   localparam logic [1:0] RST_KIND_DEFAULT = 2'd3;

   function automatic bod_act_e default_act(input int unsigned src);
      return (src == SRC_MAIN) ? ACT_RESET : ACT_NONE;
   endfunction

endpackage

// File: rtl/bod_sync.sv
module bod_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("bod_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], async_i};
         prev_q <= sh_q[STAGES-1];
      end
   end

   assign level_o = sh_q[STAGES-1];
   assign rise_o  = sh_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/bod_decode.sv
module bod_decode
   import bod_pkg::*;
(
   input  bod_act_e   act_i,
   input  logic [1:0] kind_i,
   input  logic       rise_i,
   output logic       stat_set_o,
   output logic       nmi_req_o,
   output logic       rst_req_o
);

   always_comb begin
      stat_set_o = rise_i && (act_i != ACT_NONE);
      nmi_req_o  = rise_i && (act_i == ACT_NMI);
      // kind codes 2 and 3 turn a reset action into a real reset
      rst_req_o  = rise_i && (act_i == ACT_RESET) && kind_i[1];
   end

endmodule

// File: rtl/bod_seq.sv
module bod_seq
   import bod_pkg::*;
#(
   parameter int unsigned INIT_CYCLES = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_i,
   input  logic               full_i,
   input  logic [NUM_SRC-1:0] req_src_i,
   input  logic [NUM_SRC-1:0] lvl_i,
   output logic               por_o,
   output logic               sys_o,
   output logic               enter_por_o
);

   if (INIT_CYCLES < 2) begin : g_bad_init
      $error("bod_seq: INIT_CYCLES must be at least 2");
   end

   localparam int unsigned    CNT_W    = (INIT_CYCLES > 2) ? $clog2(INIT_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

   bod_seq_e           state_q;
   logic [NUM_SRC-1:0] hold_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [NUM_SRC-1:0] hold_all;
   logic               supply_ok;

   assign hold_all  = hold_q | req_src_i;
   assign supply_ok = (hold_all & lvl_i) == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_RUN;
         hold_q  <= '0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            SEQ_RUN: begin
               if (req_i) begin
                  hold_q  <= req_src_i;
                  state_q <= full_i ? SEQ_HOLD_POR : SEQ_HOLD_SYS;
               end
            end
            SEQ_HOLD_POR: begin
               hold_q <= hold_all;
               if (supply_ok) begin
                  state_q <= SEQ_INIT;
                  cnt_q   <= '0;
                  hold_q  <= '0;
               end
            end
            SEQ_HOLD_SYS: begin
               hold_q <= hold_all;
               if (supply_ok) begin
                  state_q <= SEQ_RUN;
                  hold_q  <= '0;
               end
            end
            SEQ_INIT: begin
               if (req_i) begin
                  hold_q  <= req_src_i;
                  state_q <= SEQ_HOLD_POR;
               end else if (cnt_q == CNT_LAST) begin
                  state_q <= SEQ_RUN;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= SEQ_RUN;
         endcase
      end
   end

   assign por_o       = (state_q == SEQ_HOLD_POR) || (state_q == SEQ_INIT);
   assign sys_o       = (state_q == SEQ_HOLD_SYS);
   assign enter_por_o = (state_q == SEQ_RUN) && req_i && full_i;

   // R6: a hold persists while a requesting supply is still low-voltage
   assert_hold_while_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == SEQ_HOLD_POR || state_q == SEQ_HOLD_SYS) && ((hold_q & lvl_i) != '0))
      |=> (por_o || sys_o));

   // R5: the initialization phase keeps the power-on reset asserted
   assert_init_holds_por_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_INIT && cnt_q != CNT_LAST) |=> por_o);

   // R5: the two reset outputs never overlap
   assert_reset_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(por_o && sys_o));

endmodule

// File: rtl/bod_reset_ctrl.sv
module bod_reset_ctrl
   import bod_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned INIT_CYCLES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             main_low_i,
   input  logic             ana_low_i,
   input  logic             reg_we_i,
   input  logic [1:0]       reg_addr_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   output logic [REG_W-1:0] reg_rdata_o,
   output logic             irq_o,
   output logic             nmi_o,
   output logic             por_o,
   output logic             sysrst_o
);

   localparam int unsigned KIND_LSB = 2 * NUM_SRC;

   logic [NUM_SRC-1:0] flag_in;
   logic [NUM_SRC-1:0] lvl;
   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] stat_set;
   logic [NUM_SRC-1:0] nmi_req;
   logic [NUM_SRC-1:0] rst_req;

   bod_act_e   act_q [NUM_SRC];
   logic [1:0] kind_q;
   logic       mask_q;
   logic       raw_q;
   logic       cause_q;
   logic       nmi_q;

   logic busy;
   logic wr_ok;
   logic enter_por;
   logic clr_raw;
   logic clr_cause;

   assign flag_in[SRC_MAIN] = main_low_i;
   assign flag_in[SRC_ANA]  = ana_low_i;

   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
      bod_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (flag_in[gi]),
         .level_o (lvl[gi]),
         .rise_o  (rise[gi])
      );
      bod_decode i_decode (
         .act_i      (act_q[gi]),
         .kind_i     (kind_q),
         .rise_i     (rise[gi]),
         .stat_set_o (stat_set[gi]),
         .nmi_req_o  (nmi_req[gi]),
         .rst_req_o  (rst_req[gi])
      );
   end

   bod_seq #(.INIT_CYCLES(INIT_CYCLES)) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (|rst_req),
      .full_i      (kind_q[0]),
      .req_src_i   (rst_req),
      .lvl_i       (lvl),
      .por_o       (por_o),
      .sys_o       (sysrst_o),
      .enter_por_o (enter_por)
   );

   assign busy      = por_o | sysrst_o;
   assign wr_ok     = reg_we_i & ~busy;
   assign clr_raw   = wr_ok && (reg_addr_i == ADDR_STAT) && reg_wdata_i[0];
   assign clr_cause = wr_ok && (reg_addr_i == ADDR_STAT) && reg_wdata_i[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SRC; i++) act_q[i] <= default_act(i);
         kind_q  <= RST_KIND_DEFAULT;
         mask_q  <= 1'b0;
         raw_q   <= 1'b0;
         cause_q <= 1'b0;
         nmi_q   <= 1'b0;
      end else begin
         if (enter_por) begin
            for (int i = 0; i < NUM_SRC; i++) act_q[i] <= default_act(i);
            kind_q <= RST_KIND_DEFAULT;
            mask_q <= 1'b0;
         end else if (wr_ok && reg_addr_i == ADDR_CTRL) begin
            for (int i = 0; i < NUM_SRC; i++) act_q[i] <= bod_act_e'(reg_wdata_i[2*i +: 2]);
            kind_q <= reg_wdata_i[KIND_LSB +: 2];
         end else if (wr_ok && reg_addr_i == ADDR_MASK) begin
            mask_q <= reg_wdata_i[0];
         end
         // a new event wins over a clear arriving on the same edge
         raw_q   <= (raw_q & ~clr_raw) | (|stat_set);
         cause_q <= (cause_q & ~clr_cause) | (|rst_req);
         nmi_q   <= |nmi_req;
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         ADDR_CTRL: begin
            for (int i = 0; i < NUM_SRC; i++) reg_rdata_o[2*i +: 2] = act_q[i];
            reg_rdata_o[KIND_LSB +: 2] = kind_q;
         end
         ADDR_MASK: reg_rdata_o[0] = mask_q;
         ADDR_STAT: begin
            reg_rdata_o[0] = raw_q;
            reg_rdata_o[1] = raw_q & mask_q;
            reg_rdata_o[2] = cause_q;
         end
         default: reg_rdata_o = '0;
      endcase
   end

   assign irq_o = raw_q & mask_q;
   assign nmi_o = nmi_q;

   // R8: the cause bit only rises together with an asserted reset output
   assert_cause_with_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cause_q) |-> (por_o || sysrst_o));

   // R4: an NMI pulse is always accompanied by the raw status bit
   assert_nmi_sets_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |-> raw_q);

   // R9: the raw bit is sticky until software clears it
   assert_raw_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q && !clr_raw) |=> raw_q);

   // R11: configuration does not move while a reset is asserted
   assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(kind_q) && $stable(mask_q) && $stable(act_q[SRC_MAIN])
                && $stable(act_q[SRC_ANA])));

endmodule

// File: tb/test_bod_reset_ctrl.sv
`timescale 1ns/1ps
module test_bod_reset_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       main_low = 1'b0;
   logic       ana_low = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [5:0] reg_wdata = 6'd0;
   logic [5:0] reg_rdata;
   logic       irq, nmi, por, sysrst;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   bod_reset_ctrl i_bod_reset_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .main_low_i  (main_low),
      .ana_low_i   (ana_low),
      .reg_we_i    (reg_we),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .irq_o       (irq),
      .nmi_o       (nmi),
      .por_o       (por),
      .sysrst_o    (sysrst)
   );

   typedef struct packed {
      logic [5:0] ctrl;
      logic       mask;
      logic       src_ana;
      logic       e_raw;
      logic       e_nmi;
      logic       e_sys;
      logic       e_cause;
   } vec_t;

   // ctrl = {kind[1:0], ana_act[1:0], main_act[1:0]}
   localparam vec_t VECS [0:9] = '{
      '{6'h31, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 irq masked off
      '{6'h31, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 irq enabled
      '{6'h34, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R9 analog source
      '{6'h30, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 main none
      '{6'h33, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 analog none
      '{6'h32, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 nmi
      '{6'h23, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R6 system reset
      '{6'h13, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R7 kind 1 fallback
      '{6'h0C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R7 kind 0 fallback
      '{6'h2C, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}   // R6 analog system reset
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [5:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [5:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic set_flag(input logic ana, input logic v);
      if (ana) ana_low = v;
      else     main_low = v;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : main
      logic [5:0] d;
      wait_neg(3);
      // R1 reset state
      check("R1 por during reset", por, 0);
      rst_n = 1'b1;
      wait_neg(2);
      rd(2'd0, d); check("R1 ctrl default", d, 6'h33);
      rd(2'd1, d); check("R1 mask default", d, 6'h00);
      rd(2'd2, d); check("R1 status default", d, 6'h00);
      check("R1 outputs low", {irq, nmi, por, sysrst}, 4'b0000);

      // table walk
      for (int v = 0; v < 10; v++) begin
         wr(2'd2, 6'h05);
         wr(2'd0, VECS[v].ctrl);
         wr(2'd1, {5'd0, VECS[v].mask});
         set_flag(VECS[v].src_ana, 1'b1);
         wait_neg(2);
         check("R12 no effect before third edge", {nmi, sysrst}, 2'b00);
         wait_neg(1);
         check("R4 nmi pulse", nmi, VECS[v].e_nmi);
         wait_neg(1);
         check("R4 nmi one cycle", nmi, 0);
         rd(2'd2, d);
         check("R3/R7/R8 status", d,
               {3'd0, VECS[v].e_cause, VECS[v].e_raw & VECS[v].mask, VECS[v].e_raw});
         check("R3 irq", irq, VECS[v].e_raw & VECS[v].mask);
         check("R6 sysrst", sysrst, VECS[v].e_sys);
         check("R2 no por", por, 0);
         set_flag(VECS[v].src_ana, 1'b0);
         wait_neg(5);
         check("R6 sysrst released", sysrst, 0);
         rd(2'd2, d);
         check("R8 cause after system reset", d[2], VECS[v].e_cause);
         wr(2'd2, 6'h05);
         rd(2'd2, d);
         check("R9 W1C clears status", d, 6'h00);
      end

      // R10 set beats clear
      wr(2'd0, 6'h35);
      wr(2'd1, 6'h00);
      ana_low = 1'b1; wait_neg(4);
      ana_low = 1'b0; wait_neg(4);
      rd(2'd2, d); check("R9 analog sets raw", d[0], 1);
      main_low = 1'b1;
      wait_neg(2);
      reg_addr = 2'd2; reg_wdata = 6'h01; reg_we = 1'b1;
      wait_neg(1);
      reg_we = 1'b0;
      rd(2'd2, d); check("R10 set wins over clear", d[0], 1);
      main_low = 1'b0; wait_neg(4);
      wr(2'd2, 6'h01);
      rd(2'd2, d); check("R9 clear alone", d[0], 0);

      // R6 both sources, release after last flag
      wr(2'd2, 6'h05);
      wr(2'd0, 6'h2F);
      main_low = 1'b1; ana_low = 1'b1;
      wait_neg(4);
      check("R6 sysrst both", sysrst, 1);
      main_low = 1'b0;
      wait_neg(5);
      check("R6 held by analog", sysrst, 1);
      ana_low = 1'b0;
      wait_neg(2);
      check("R6 still held", sysrst, 1);
      wait_neg(1);
      check("R6 release timing", sysrst, 0);
      rd(2'd0, d); check("R6 config kept", d, 6'h2F);

      // R5 full power-on reset
      wr(2'd2, 6'h05);
      wr(2'd0, 6'h3F);
      wr(2'd1, 6'h01);
      main_low = 1'b1;
      wait_neg(2);
      check("R12 por not yet", por, 0);
      wait_neg(1);
      check("R5 por asserted", por, 1);
      rd(2'd0, d); check("R5 ctrl restored", d, 6'h33);
      rd(2'd1, d); check("R5 mask restored", d, 6'h00);
      rd(2'd2, d); check("R8 cause set", d[2], 1);
      wr(2'd0, 6'h00);
      rd(2'd0, d); check("R11 write ignored", d, 6'h33);
      wait_neg(10);
      check("R5 held while low", por, 1);
      main_low = 1'b0;
      wait_neg(18);
      check("R5 init last cycle", por, 1);
      wait_neg(1);
      check("R5 init done", por, 0);
      check("R5 no sysrst", sysrst, 0);

      // R8 external reset clears cause
      rd(2'd2, d); check("R8 cause kept", d[2], 1);
      rst_n = 1'b0;
      wait_neg(2);
      rst_n = 1'b1;
      wait_neg(1);
      rd(2'd2, d); check("R8 cleared by reset", d, 6'h00);
      rd(2'd0, d); check("R1 ctrl after reset", d, 6'h33);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule